// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter

This block chooses which interrupt, if any, a processor core takes at the end of the current instruction. Five sources compete: a non-maskable request, three maskable requests that are serviced by an internal restart (levels 7.5, 6.5 and 5.5), and a general request that an external device completes during an acknowledge cycle. The core raises a sample strobe once per instruction, on the next-to-last clock. On that clock the arbiter checks the global enable flag and the per-level mask bits, picks the highest-priority request still eligible, and in the following cycle gives an accept pulse, a restart address, and the signals that hold the program counter and start an acknowledge.

Instruction-driven commands set and clear the global enable and write the three mask bits. Level 7.5 is caught on its rising edge and stays pending until it is serviced or cleared by software. Levels 6.5 and 5.5 are level-sensitive. Accepting any interrupt clears the global enable.

Top module: `irq_arbiter`

## Requirements
- R1: The fixed priority from highest to lowest is non-maskable, level 7.5, level 6.5, level 5.5, general request. Only the highest eligible source is accepted.
- R2: The non-maskable request is accepted whatever the global enable and mask bits hold.
- R3: Requests are evaluated only in a cycle where `sample_i` is 1. Requests present in any other cycle produce no accept.
- R4: Accepting the general request drives `inta_o`=1, `pc_hold_o`=1 and `vector_o`=0x0000.
- R5: Accepting an internal restart drives `inta_o`=0 and `pc_hold_o`=1, with `vector_o` set to 0x0024 (non-maskable), 0x003C (7.5), 0x0034 (6.5) or 0x002C (5.5).
- R6: Reset clears the global enable. Accepting any interrupt also clears it, so a maskable or general request held after an accept is not taken again until the enable is set once more.
- R7: `ei_i` sets the global enable and `di_i` clears it. When both are given in the same cycle, `di_i` wins.
- R8: A mask write (`mask_wr_i`) updates the mask bits only when `mask_en_i` is 1. Bit 0 masks level 5.5, bit 1 masks 6.5 and bit 2 masks 7.5, where 1 means masked. All bits are 1 after reset.
- R9: A rising edge on `rst75_i` sets a pending flag. The flag survives masking and stays set until level 7.5 is accepted or `clr75_i` is given. A level held high does not set it again.
- R10: `accept_o` is a one-cycle pulse in the cycle after the sampling edge, and `vector_o`, `inta_o` and `pc_hold_o` are valid only with it (otherwise 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_i | input | 1 | Non-maskable request |
| rst75_i | input | 1 | Level 7.5 request (edge captured) |
| rst65_i | input | 1 | Level 6.5 request (level) |
| rst55_i | input | 1 | Level 5.5 request (level) |
| intr_i | input | 1 | General request, completed by an external acknowledge |
| sample_i | input | 1 | Next-to-last clock of the current instruction |
| ei_i | input | 1 | Set global enable |
| di_i | input | 1 | Clear global enable |
| mask_wr_i | input | 1 | Mask write command |
| mask_en_i | input | 1 | Mask write qualifier |
| mask_val_i | input | 3 | New mask bits {7.5, 6.5, 5.5} |
| clr75_i | input | 1 | Software clear of the level 7.5 pending flag |
| accept_o | output | 1 | Interrupt accepted |
| vector_o | output | 16 | Restart address |
| inta_o | output | 1 | Start an acknowledge cycle for the general request |
| pc_hold_o | output | 1 | Stop the program counter from incrementing |

## Verification
The arbiter is driven with one source at a time, which confirms each vector and acknowledge pattern, and then with stacked sources that are added one level higher at a time, which shows that only the top eligible level wins. Enable and mask patterns are varied while the requests stay the same: a non-maskable request with everything disabled, an unqualified mask write followed by a qualified one, and enable and disable given in the same cycle. These show which state gates which source. For level 7.5 the bench holds the level high, clears it by software, and masks a pending edge and later unmasks it. This separates edge capture from level sensing.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NUM_SRC = 5;
  localparam int NUM_MSK = 3;
  // index order is priority order, 0 highest
  typedef enum logic [2:0] {
    SRC_TRAP = 3'd0,
    SRC_R75  = 3'd1,
    SRC_R65  = 3'd2,
    SRC_R55  = 3'd3,
    SRC_INTR = 3'd4
  } src_e;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic clr_i,
  input  logic take_i,
  output logic pend_o
);
  logic lvl_q, pend_q, rise;

  assign rise = lvl_i & ~lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_i;
      pend_q <= rise | (pend_q & ~clr_i & ~take_i);
    end
  end

  assign pend_o = pend_q;

  p_edge_sets_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i && !lvl_q) |=> pend_o);
  p_pend_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !clr_i && !take_i) |=> pend_o);
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
  parameter int MSK_W = irq_arb_pkg::NUM_MSK
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ei_i,
  input  logic             di_i,
  input  logic             take_i,
  input  logic             mask_wr_i,
  input  logic             mask_en_i,
  input  logic [MSK_W-1:0] mask_val_i,
  output logic             ie_o,
  output logic [MSK_W-1:0] mask_o
);
  logic             ie_q;
  logic [MSK_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q   <= 1'b0;
      mask_q <= '1;
    end else begin
      // accept and disable override enable
      if (take_i || di_i) ie_q <= 1'b0;
      else if (ei_i)      ie_q <= 1'b1;
      if (mask_wr_i && mask_en_i) mask_q <= mask_val_i;
    end
  end

  assign ie_o   = ie_q;
  assign mask_o = mask_q;

  p_take_clears_ie_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> !ie_o);
  p_di_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    di_i |=> !ie_o);
  p_mask_qualified_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mask_wr_i && mask_en_i) |=> $stable(mask_o));
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int N = irq_arb_pkg::NUM_SRC
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         valid_o
);
  always_comb begin
    gnt_o   = '0;
    valid_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !valid_o) begin
        gnt_o[i] = 1'b1;
        valid_o  = 1'b1;
      end
    end
  end

  p_gnt_onehot_r1: assert property (@(req_i) 1'b1 |-> $onehot0(gnt_o))
    else ;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] VEC_TRAP = 16'h0024,
  parameter logic [15:0] VEC_R75  = 16'h003C,
  parameter logic [15:0] VEC_R65  = 16'h0034,
  parameter logic [15:0] VEC_R55  = 16'h002C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trap_i,
  input  logic              rst75_i,
  input  logic              rst65_i,
  input  logic              rst55_i,
  input  logic              intr_i,
  input  logic              sample_i,
  input  logic              ei_i,
  input  logic              di_i,
  input  logic              mask_wr_i,
  input  logic              mask_en_i,
  input  logic [2:0]        mask_val_i,
  input  logic              clr75_i,
  output logic              accept_o,
  output logic [ADDR_W-1:0] vector_o,
  output logic              inta_o,
  output logic              pc_hold_o
);
  import irq_arb_pkg::*;

  logic               ie;
  logic [NUM_MSK-1:0] mask;
  logic               pend75;
  logic [NUM_SRC-1:0] req, gnt;
  logic               any, take;
  logic [ADDR_W-1:0]  vec_sel;

  assign take = sample_i & any;

  irq_ctrl_regs #(.MSK_W(NUM_MSK)) u_regs (
    .clk_i, .rst_ni, .ei_i, .di_i, .take_i(take),
    .mask_wr_i, .mask_en_i, .mask_val_i,
    .ie_o(ie), .mask_o(mask)
  );

  irq_edge_latch u_r75 (
    .clk_i, .rst_ni, .lvl_i(rst75_i), .clr_i(clr75_i),
    .take_i(take & gnt[SRC_R75]), .pend_o(pend75)
  );

  // mask bit order: 0 -> 5.5, 1 -> 6.5, 2 -> 7.5
  always_comb begin
    req           = '0;
    req[SRC_TRAP] = trap_i;
    req[SRC_R75]  = pend75  & ie & ~mask[2];
    req[SRC_R65]  = rst65_i & ie & ~mask[1];
    req[SRC_R55]  = rst55_i & ie & ~mask[0];
    req[SRC_INTR] = intr_i  & ie;
  end

  irq_prio_sel #(.N(NUM_SRC)) u_sel (
    .req_i(req), .gnt_o(gnt), .valid_o(any)
  );

  always_comb begin
    vec_sel = '0;
    if      (gnt[SRC_TRAP]) vec_sel = ADDR_W'(VEC_TRAP);
    else if (gnt[SRC_R75])  vec_sel = ADDR_W'(VEC_R75);
    else if (gnt[SRC_R65])  vec_sel = ADDR_W'(VEC_R65);
    else if (gnt[SRC_R55])  vec_sel = ADDR_W'(VEC_R55);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o  <= 1'b0;
      vector_o  <= '0;
      inta_o    <= 1'b0;
      pc_hold_o <= 1'b0;
    end else begin
      accept_o  <= take;
      pc_hold_o <= take;
      inta_o    <= take & gnt[SRC_INTR];
      vector_o  <= take ? vec_sel : '0;
    end
  end

  p_only_on_sample_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> $past(sample_i));
  p_trap_wins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && trap_i) |=> (accept_o && vector_o == ADDR_W'(VEC_TRAP) && !inta_o));
  p_inta_form_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_o |-> (accept_o && pc_hold_o && vector_o == '0));
  p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_o |-> (!inta_o && !pc_hold_o && vector_o == '0));
  p_ie_low_after_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> !ie);
endmodule

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap = 0, r75 = 0, r65 = 0, r55 = 0, intr = 0, smp = 0;
  logic ei = 0, di = 0, mwr = 0, men = 0, clr75 = 0;
  logic [2:0] mval = 3'b111;
  logic acc, inta, hold;
  logic [15:0] vec;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  irq_arbiter u0 (
    .clk_i(clk), .rst_ni(rst_n), .trap_i(trap), .rst75_i(r75), .rst65_i(r65),
    .rst55_i(r55), .intr_i(intr), .sample_i(smp), .ei_i(ei), .di_i(di),
    .mask_wr_i(mwr), .mask_en_i(men), .mask_val_i(mval), .clr75_i(clr75),
    .accept_o(acc), .vector_o(vec), .inta_o(inta), .pc_hold_o(hold)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // outputs packed {acc, inta, hold, vec}
  task automatic do_sample(string tag, logic a, logic i, logic [15:0] v);
    @(negedge clk) smp = 1;
    @(negedge clk) smp = 0;
    chk(tag, {acc, inta, hold, vec}, {a, i, a, v});
  endtask

  task automatic pulse_ei();
    @(negedge clk) ei = 1;
    @(negedge clk) ei = 0;
  endtask

  task automatic set_mask(logic en, logic [2:0] m);
    @(negedge clk) begin mwr = 1; men = en; mval = m; end
    @(negedge clk) begin mwr = 0; men = 0; end
  endtask

  task automatic t_reset();
    chk("R10 reset outputs", {acc, inta, hold, vec}, 0);
    intr = 1;
    do_sample("R6 ie clear after reset", 0, 0, 16'h0);
    intr = 0;
  endtask

  task automatic t_trap();
    trap = 1;
    do_sample("R2 trap with ie off and all masked", 1, 0, 16'h0024);
    trap = 0;
    @(negedge clk);
    chk("R10 accept is one pulse", {acc, hold, vec}, 0);
  endtask

  task automatic t_intr();
    pulse_ei();
    intr = 1;
    do_sample("R4 general request acknowledge", 1, 1, 16'h0000);
    do_sample("R6 accept cleared enable", 0, 0, 16'h0);
    intr = 0;
  endtask

  task automatic t_sample_gate();
    pulse_ei();
    set_mask(1, 3'b000);
    r65 = 1;
    repeat (4) @(negedge clk);
    chk("R3 no accept without sample", {acc, hold}, 0);
    do_sample("R5 level 6.5 vector", 1, 0, 16'h0034);
    r65 = 0;
  endtask

  task automatic t_mask();
    set_mask(1, 3'b111);
    pulse_ei();
    set_mask(0, 3'b000);
    r55 = 1;
    do_sample("R8 unqualified mask write ignored", 0, 0, 16'h0);
    set_mask(1, 3'b110);
    do_sample("R8 qualified unmask of 5.5", 1, 0, 16'h002C);
    r55 = 0;
  endtask

  task automatic t_prio();
    set_mask(1, 3'b000);
    pulse_ei();
    r55 = 1; r65 = 1; intr = 1;
    do_sample("R1 6.5 over 5.5 and general", 1, 0, 16'h0034);
    pulse_ei();
    @(negedge clk) r75 = 1;
    do_sample("R1 7.5 over lower levels", 1, 0, 16'h003C);
    pulse_ei();
    trap = 1;
    do_sample("R1 trap over all", 1, 0, 16'h0024);
    trap = 0;
    pulse_ei();
    do_sample("R9 held 7.5 level no retrigger", 1, 0, 16'h0034);
    r55 = 0; r65 = 0; intr = 0; r75 = 0;
  endtask

  task automatic t_edge();
    pulse_ei();
    @(negedge clk) r75 = 1;
    @(negedge clk) begin r75 = 0; clr75 = 1; end
    @(negedge clk) clr75 = 0;
    do_sample("R9 software clear drops pending", 0, 0, 16'h0);
    set_mask(1, 3'b100);
    @(negedge clk) r75 = 1;
    @(negedge clk) r75 = 0;
    do_sample("R9 masked edge not taken", 0, 0, 16'h0);
    set_mask(1, 3'b000);
    do_sample("R9 pending survives mask", 1, 0, 16'h003C);
    pulse_ei();
    do_sample("R9 serviced edge cleared", 0, 0, 16'h0);
  endtask

  task automatic t_ei_di();
    @(negedge clk) begin ei = 1; di = 1; end
    @(negedge clk) begin ei = 0; di = 0; end
    intr = 1;
    do_sample("R7 disable wins over enable", 0, 0, 16'h0);
    pulse_ei();
    @(negedge clk) di = 1;
    @(negedge clk) di = 0;
    do_sample("R7 disable clears enable", 0, 0, 16'h0);
    pulse_ei();
    do_sample("R7 enable sets enable", 1, 1, 16'h0);
    intr = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_trap();
    t_intr();
    t_sample_gate();
    t_mask();
    t_prio();
    t_edge();
    t_ei_di();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule